// File: doc/BRIEF.md
# Bus-Mapped Timekeeping and Prescaled Event Counter

This peripheral sits on a simple 32-bit register bus. Each access is one cycle. A write is qualified by a write strobe. A read is qualified by a read strobe, and its data is returned in a register on the following cycle. The register file holds three plain registers. The first is a two-bit LED value. The second is a button location that always reads as zero. The third is a 32-bit scratch control word that is stored and returned but drives nothing.

The main function is timekeeping. Two free-running counters advance at 1 Hz and at 100 Hz. A third pair of registers forms an event counter driven by a reference tick, which runs at 20 MHz by default. A down-counting prescaler spends `reload + 1` reference ticks per event: it counts down to zero, bumps the 32-bit event counter, and reloads from a programmable value. All three tick rates are enable pulses divided down from the system clock, so a frequency parameter for the system clock sets the divisors. Software can read and overwrite every counter while it runs.

Top module: `fpgaio_timer`

## Requirements
- R1: While reset is low and after it is released, every register (LED, scratch, both time counters, event counter, prescaler, reload) holds zero, and the read data output is zero.
- R2: The LED register is at offset 0x00. A write keeps only bits [1:0], and a read returns those bits with bits [31:2] zero.
- R3: Offset 0x08 always reads as zero. The scratch register at offset 0x4C keeps all 32 written bits and reads them back unchanged.
- R4: The seconds counter at offset 0x10 increments by one every DIV1 = SYS_CLK_HZ system cycles. Its divider fires on the DIV1-th cycle after reset release and then every DIV1 cycles. A write loads the value, and counting continues from it.
- R5: The centisecond counter at offset 0x14 behaves the same way with DIV100 = SYS_CLK_HZ/100.
- R6: On each reference tick, which fires every SYS_CLK_HZ/REF_TICK_HZ cycles with the same phase rule as R4, the prescaler (offset 0x20) decrements when it is nonzero. When it is zero, the event counter (offset 0x18) increments and the prescaler loads the reload value (offset 0x1C).
- R7: With a reload value of 0, the event counter increments on every reference tick and the prescaler stays at 0.
- R8: Writing the reload value leaves the current prescaler count unchanged. The new value takes effect at the next reload.
- R9: A bus write to a counter in the same cycle as its tick wins over the increment or decrement. Other updates from that tick still happen.
- R10: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register. Any offset not listed in R2 to R8 is unmapped, including offsets that are not word aligned.
- R11: Read data appears on the cycle after the read strobe and shows register contents from before that clock edge. It holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset in the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that each strobe stands for one complete access. They also assume that the address and write data are stable while a strobe is high, and that read and write are never raised together. The random stimulus keeps to these rules: it issues at most one access per cycle and drives every input half a cycle away from the sampling edge. Collisions between a write and a tick are not avoided. They are aimed for deliberately by waiting until the bench's own divider model predicts a tick on the next edge.

// File: rtl/fpgaio_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register offsets and the offset decoder.
// Assumes a 4 KiB byte-addressed window and 32-bit registers.
package fpgaio_timer_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LED_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_LED     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_BUTTON  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SECONDS = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CENTI   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_EVENTS  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_PRESC   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 12'h04C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BUTTON,
        SEL_SECONDS,
        SEL_CENTI,
        SEL_EVENTS,
        SEL_RELOAD,
        SEL_PRESC,
        SEL_SCRATCH
    } reg_sel_e;

    // Map a byte offset to a register select; anything unlisted is SEL_NONE.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        case (ofs)
            OFS_LED:     return SEL_LED;
            OFS_BUTTON:  return SEL_BUTTON;
            OFS_SECONDS: return SEL_SECONDS;
            OFS_CENTI:   return SEL_CENTI;
            OFS_EVENTS:  return SEL_EVENTS;
            OFS_RELOAD:  return SEL_RELOAD;
            OFS_PRESC:   return SEL_PRESC;
            OFS_SCRATCH: return SEL_SCRATCH;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fpgaio_tickdiv.sv
`timescale 1ns/1ps
// Module: divide-by-DIV enable generator.
// Produces a one-cycle pulse on the DIV-th cycle after reset release and every
// DIV cycles after that. With DIV of 1 the pulse is high on every cycle.
module fpgaio_tickdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count system cycles and wrap back to zero on the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fpgaio_tcount.sv
`timescale 1ns/1ps
// Module: loadable up-counter for timekeeping.
// Assumes load and tick may coincide; the load wins.
module fpgaio_tcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    // Load from the bus, otherwise advance on each enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (tick) value <= value + 1'b1;
    end
endmodule

// File: rtl/fpgaio_prescaler.sv
`timescale 1ns/1ps
// Module: prescaled event counter.
// Each reference tick decrements the prescaler when it is nonzero. When it is
// zero, the tick bumps the event counter and reloads the prescaler. Bus writes
// win over the tick for the register they target only.
module fpgaio_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_events,
    input  logic         wr_presc,
    input  logic         wr_reload,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] events,
    output logic [W-1:0] presc,
    output logic [W-1:0] reload
);
    logic at_zero;
    assign at_zero = (presc == '0);

    // Reload register: plain storage, read at each underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload <= '0;
        else if (wr_reload) reload <= wdata;
    end

    // Prescaler: bus write first, then reload or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        presc <= '0;
        else if (wr_presc) presc <= wdata;
        else if (tick)     presc <= at_zero ? reload : presc - 1'b1;
    end

    // Event counter: bus write first, then bump when a tick finds zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                events <= '0;
        else if (wr_events)        events <= wdata;
        else if (tick && at_zero)  events <= events + 1'b1;
    end
endmodule

// File: rtl/fpgaio_timer.sv
`timescale 1ns/1ps
// Module: top of the bus-mapped timekeeping block.
// Decodes single-cycle bus accesses and holds the LED and scratch registers.
// Generates the three tick enables from the system clock, and registers the
// read data. Assumes read and write strobes are not raised together.
module fpgaio_timer
    import fpgaio_timer_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int REF_TICK_HZ = 20_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int DIV_SEC   = (SYS_CLK_HZ < 1) ? 1 : SYS_CLK_HZ;
    localparam int DIV_CENTI = (SYS_CLK_HZ / 100 < 1) ? 1 : SYS_CLK_HZ / 100;
    localparam int DIV_REF   = (SYS_CLK_HZ / REF_TICK_HZ < 1) ? 1 : SYS_CLK_HZ / REF_TICK_HZ;
    localparam int NUM_TIME  = 2;

    reg_sel_e          sel;
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] scratch_q;
    logic              ref_tick;
    logic [DATA_W-1:0] ev_val, psc_val, rl_val;
    logic [NUM_TIME-1:0] time_tick, time_load;
    logic [DATA_W-1:0] time_val [NUM_TIME];

    assign sel = decode_ofs(bus_addr);
    assign time_load[0] = bus_wr && (sel == SEL_SECONDS);
    assign time_load[1] = bus_wr && (sel == SEL_CENTI);

    // One divider and one loadable counter per timekeeping rate.
    for (genvar g = 0; g < NUM_TIME; g++) begin : g_time
        localparam int DIV_G = (g == 0) ? DIV_SEC : DIV_CENTI;
        fpgaio_tickdiv #(.DIV(DIV_G)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (time_tick[g])
        );
        fpgaio_tcount #(.W(DATA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (time_tick[g]),
            .load    (time_load[g]),
            .load_val(bus_wdata),
            .value   (time_val[g])
        );
    end

    fpgaio_tickdiv #(.DIV(DIV_REF)) u_ref_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    fpgaio_prescaler #(.W(DATA_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ref_tick),
        .wr_events(bus_wr && (sel == SEL_EVENTS)),
        .wr_presc (bus_wr && (sel == SEL_PRESC)),
        .wr_reload(bus_wr && (sel == SEL_RELOAD)),
        .wdata    (bus_wdata),
        .events   (ev_val),
        .presc    (psc_val),
        .reload   (rl_val)
    );

    // LED and scratch storage written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q     <= '0;
            scratch_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_LED)     led_q     <= bus_wdata[LED_W-1:0];
            if (sel == SEL_SCRATCH) scratch_q <= bus_wdata;
        end
    end

    // Registered read mux; holds the last value when no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_LED:     bus_rdata <= {{(DATA_W-LED_W){1'b0}}, led_q};
                SEL_SECONDS: bus_rdata <= time_val[0];
                SEL_CENTI:   bus_rdata <= time_val[1];
                SEL_EVENTS:  bus_rdata <= ev_val;
                SEL_RELOAD:  bus_rdata <= rl_val;
                SEL_PRESC:   bus_rdata <= psc_val;
                SEL_SCRATCH: bus_rdata <= scratch_q;
                default:     bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fpgaio_timer_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the timekeeping block, bound to its top.
// Assumes a single access per strobe, with stable address and data while it is high.
module fpgaio_timer_chk
    import fpgaio_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ref_tick,
    input logic [DATA_W-1:0] events,
    input logic [DATA_W-1:0] presc
);
    a_r2_led_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_LED) |=> (bus_rdata[DATA_W-1:LED_W] == '0));

    a_r3_button_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_BUTTON) |=> (bus_rdata == '0));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && decode_ofs(bus_addr) == SEL_NONE) |=> (bus_rdata == '0));

    a_r6_presc_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && presc != '0 && !(bus_wr && bus_addr == OFS_PRESC))
        |=> (presc == $past(presc) - 1));

    a_r6_event_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && presc == '0 && !(bus_wr && bus_addr == OFS_EVENTS))
        |=> (events == $past(events) + 1));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EVENTS) |=> (events == $past(bus_wdata)));

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind fpgaio_timer fpgaio_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ref_tick (ref_tick),
    .events   (ev_val),
    .presc    (psc_val)
);

// File: tb/fpgaio_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: a cycle model built from the requirements runs beside the DUT.
// Seeded random accesses are mixed with directed corner cases.
module fpgaio_timer_tb_top;
    import fpgaio_timer_pkg::*;

    localparam int SYS_HZ = 1000;
    localparam int REF_HZ = 250;
    localparam int D_SEC  = SYS_HZ;
    localparam int D_CEN  = SYS_HZ / 100;
    localparam int D_REF  = SYS_HZ / REF_HZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpgaio_timer #(.SYS_CLK_HZ(SYS_HZ), .REF_TICK_HZ(REF_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Model state
    logic [1:0]  m_led;
    logic [31:0] m_scr, m_sec, m_cen, m_ev, m_ps, m_rl, m_rd;
    int m_dsec, m_dcen, m_dref;

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LED:     return {30'd0, m_led};
            OFS_SECONDS: return m_sec;
            OFS_CENTI:   return m_cen;
            OFS_EVENTS:  return m_ev;
            OFS_RELOAD:  return m_rl;
            OFS_PRESC:   return m_ps;
            OFS_SCRATCH: return m_scr;
            default:     return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LED:                 return "R2";
            OFS_BUTTON, OFS_SCRATCH: return "R3";
            OFS_SECONDS:             return "R4";
            OFS_CENTI:               return "R5";
            OFS_EVENTS, OFS_PRESC:   return "R6";
            OFS_RELOAD:              return "R8";
            default:                 return "R10";
        endcase
    endfunction

    // Reference model, advanced on each rising edge from the same inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_led = 0; m_scr = 0; m_sec = 0; m_cen = 0; m_ev = 0; m_ps = 0;
            m_rl = 0; m_rd = 0; m_dsec = 0; m_dcen = 0; m_dref = 0;
        end else begin
            logic ts, tc, tr;
            logic [31:0] ev_n, ps_n;
            ts = (m_dsec == D_SEC - 1);
            tc = (m_dcen == D_CEN - 1);
            tr = (m_dref == D_REF - 1);
            if (bus_rd) m_rd = model_read(bus_addr);
            ev_n = m_ev;
            ps_n = m_ps;
            if (tr) begin
                if (m_ps == 0) begin ev_n = m_ev + 1; ps_n = m_rl; end
                else ps_n = m_ps - 1;
            end
            if (ts) m_sec = m_sec + 1;
            if (tc) m_cen = m_cen + 1;
            if (bus_wr) begin
                case (bus_addr)
                    OFS_LED:     m_led = bus_wdata[1:0];
                    OFS_SCRATCH: m_scr = bus_wdata;
                    OFS_SECONDS: m_sec = bus_wdata;
                    OFS_CENTI:   m_cen = bus_wdata;
                    OFS_EVENTS:  ev_n = bus_wdata;
                    OFS_PRESC:   ps_n = bus_wdata;
                    OFS_RELOAD:  m_rl = bus_wdata;
                    default: ;
                endcase
            end
            m_ev = ev_n; m_ps = ps_n;
            m_dsec = ts ? 0 : m_dsec + 1;
            m_dcen = tc ? 0 : m_dcen + 1;
            m_dref = tr ? 0 : m_dref + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, m_rd);
    endtask

    task automatic wait_ref_tick();
        while (m_dref != D_REF - 1) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        bus_read(OFS_LED, tag);     bus_read(OFS_SCRATCH, tag);
        bus_read(OFS_SECONDS, tag); bus_read(OFS_CENTI, tag);
        bus_read(OFS_EVENTS, tag);  bus_read(OFS_PRESC, tag);
        bus_read(OFS_RELOAD, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] addrs [13];
        void'($urandom(32'h5EED_0042));
        addrs = '{OFS_LED, OFS_BUTTON, OFS_SECONDS, OFS_CENTI, OFS_EVENTS,
                  OFS_RELOAD, OFS_PRESC, OFS_SCRATCH, 12'h004, 12'h00C,
                  12'h024, 12'hFFC, 12'h04D};
        repeat (4) @(negedge clk);
        check("R1", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all registers read back as zero shortly after reset
        bus_read(OFS_LED, "R1"); bus_read(OFS_SCRATCH, "R1");
        bus_read(OFS_SECONDS, "R1"); bus_read(OFS_EVENTS, "R1");
        check("R1", m_sec, 32'd0);

        // R2: only two LED bits kept
        bus_write(OFS_LED, 32'hFFFF_FFFE);
        bus_read(OFS_LED, "R2");
        check("R2", bus_rdata, 32'd2);
        // R3: button zero, scratch full width
        bus_read(OFS_BUTTON, "R3");
        bus_write(OFS_SCRATCH, 32'hA5C3_0F69);
        bus_read(OFS_SCRATCH, "R3");
        check("R3", bus_rdata, 32'hA5C3_0F69);

        // R7: zero reload, event counter bumps on every reference tick
        bus_write(OFS_RELOAD, 0); bus_write(OFS_PRESC, 0); bus_write(OFS_EVENTS, 0);
        repeat (40) @(negedge clk);
        bus_read(OFS_PRESC, "R7");
        check("R7", bus_rdata, 32'd0);
        bus_read(OFS_EVENTS, "R7");

        // R8: reload write leaves the live prescaler alone
        bus_write(OFS_PRESC, 50);
        bus_write(OFS_RELOAD, 7);
        bus_read(OFS_PRESC, "R8");
        bus_read(OFS_RELOAD, "R8");
        repeat (260) @(negedge clk);
        bus_read(OFS_PRESC, "R8");
        bus_read(OFS_EVENTS, "R6");

        // R9: writes collide with a reference tick
        bus_write(OFS_PRESC, 0);
        wait_ref_tick();
        bus_write(OFS_EVENTS, 32'h0000_0100);
        bus_read(OFS_EVENTS, "R9");
        bus_read(OFS_PRESC, "R9");
        wait_ref_tick();
        bus_write(OFS_PRESC, 32'd3);
        bus_read(OFS_PRESC, "R9");
        bus_read(OFS_EVENTS, "R9");

        // R4 / R5: load time counters and let them run
        bus_write(OFS_SECONDS, 32'hFFFF_FFFF);
        bus_write(OFS_CENTI, 32'd1000);
        repeat (1100) @(negedge clk);
        bus_read(OFS_SECONDS, "R4");
        bus_read(OFS_CENTI, "R5");

        // R10: unmapped writes change nothing, reads give zero
        bus_write(12'h004, 32'hDEAD_BEEF);
        bus_write(12'h04D, 32'h1234_5678);
        bus_write(12'hFFC, 32'h0BAD_F00D);
        read_all("R10");
        bus_read(12'h024, "R10");

        // R11: read data holds across idle cycles
        bus_read(OFS_SCRATCH, "R11");
        repeat (3) @(negedge clk);
        check("R11", bus_rdata, m_rd);

        // Random mixed traffic
        for (int i = 0; i < 20000; i++) begin
            int op = $urandom_range(0, 9);
            logic [ADDR_W-1:0] a = addrs[$urandom_range(0, 12)];
            if (op < 4) @(negedge clk);
            else if (op < 7) bus_read(a, tag_of(a));
            else if ($urandom_range(0, 3) == 0) bus_write(a, $urandom_range(0, 5));
            else bus_write(a, $urandom);
        end
        read_all("R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule